// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block is the command side of a character display controller. A host issues single-cycle transfers of one byte, each qualified by a register-select bit (`rs_i`: 0 = command, 1 = memory data) and a direction bit (`rw_i`: 0 = write, 1 = read). Command bytes are decoded by the position of their most significant set bit. The block keeps a shared address counter for the display memory and the glyph memory, a horizontal display offset, the entry mode, the display flags and the interface setup.

Every accepted command or memory transfer makes the block busy for a fixed number of clock cycles, given by parameters. The long duration applies to clear and home, and the short one to everything else. While it is busy, the only transfer it answers is the status read. The display memory and the glyph memory are plain register arrays inside the block. Reads go through a one-entry prefetch buffer. Scan-out, font lookup and panel drive belong to other blocks.

Top module: `char_disp_ctrl`

## Requirements
- R1: After reset the block is idle and all display flags are off. It is in one-line, small-font, 8-bit-bus mode with increment entry, no entry shift and offset 0. The address counter is 0 and every display memory location holds 0x20.
- R2: A command write is decoded by its highest set bit, and bits below the operand field are ignored. bit7 loads the 7-bit display address (bits 6..0). bit6 loads the 6-bit glyph address (bits 5..0). bit5 sets the setup flags: bus width in bit4, two-line in bit3, tall font in bit2. bit4 is the shift command: bit3 selects display (1) or cursor (0), and bit2 selects right (1) or left (0). bit3 sets the display flags: on in bit2, cursor in bit1, blink in bit0. bit2 sets the entry mode: increment in bit1, shift in bit0. bit1 is home and bit0 is clear. The byte 0x00 does nothing and does not make the block busy.
- R3: Clear writes 0x20 to every display location. It zeroes the counter and the offset, selects display memory and forces increment entry, and leaves the entry-shift flag unchanged.
- R4: Home zeroes the counter and the offset and selects display memory. Memory contents are unchanged.
- R5: Every accepted memory write or read steps the counter by one, up when increment is set and down otherwise. In glyph memory the step wraps within 6 bits.
- R6: In two-line mode the display address steps from 0x27 to 0x40 and from 0x67 to 0x00, and the reverse on decrement. In one-line mode it wraps between 0x4F and 0x00.
- R7: A display memory write with entry shift set moves the offset by one: +1 (left) when incrementing and -1 (right) when decrementing. The offset wraps modulo 40 in two-line mode and modulo 80 in one-line mode. Memory reads never move the offset.
- R8: The cursor form of the shift command steps the counter like R6, in the direction of bit2. The display form moves the offset (left +1, right -1) and leaves the counter alone.
- R9: A status read returns {busy, counter} on `rdata_o` one cycle later. It is answered even while busy, and it does not start a busy period.
- R10: A data read returns the prefetch buffer. The buffer is reloaded by address loads, by cursor shifts and after each read. A first read after any other command or write therefore returns stale data.
- R11: An accepted command holds `busy_o` high for exactly SHORT_CYC cycles, or LONG_CYC cycles for clear and home. An accepted memory transfer holds it for SHORT_CYC cycles.
- R12: While busy, every transfer except the status read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer strobe, one cycle per transfer |
| rs_i | input | 1 | 0 = command/status, 1 = memory data |
| rw_i | input | 1 | 0 = write, 1 = read |
| wdata_i | input | 8 | Command or data byte |
| rdata_o | output | 8 | Read result, valid the cycle after a read |
| busy_o | output | 1 | Execution in progress |
| disp_on_o | output | 1 | Display enabled |
| cursor_on_o | output | 1 | Cursor visible |
| blink_on_o | output | 1 | Cursor blink |
| two_line_o | output | 1 | Two-line mode |
| tall_font_o | output | 1 | Tall glyph font |
| wide_bus_o | output | 1 | 8-bit bus width selected |
| entry_inc_o | output | 1 | Entry direction is increment |
| entry_shift_o | output | 1 | Display shifts on write |
| shift_ofs_o | output | 7 | Horizontal display offset |

## Verification
The bench drives the line-boundary jumps in both directions and in both line modes. An address stepper that simply adds one would land in the unused hole at 0x28, or run past 0x4F. It also checks a read straight after a write against the stale buffer value; a design that reads memory directly would return fresh data there. Transfers are sent during clear's long busy window to show they leave no trace, and every busy window is counted to the exact cycle. Offset wrap at 0 and 39, the glyph counter's 6-bit wrap, and reads that must not move the offset complete the directed part, and a seeded random command mix runs against a reference model.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_CTRL,
    OP_SHIFT, OP_FUNC, OP_CG_ADDR, OP_DD_ADDR
  } op_e;

  typedef struct packed {
    logic disp_on;
    logic cursor_on;
    logic blink_on;
    logic two_line;
    logic tall_font;
    logic wide_bus;
    logic inc;
    logic eshift;
  } cfg_t;

  localparam int unsigned AC_W    = 7;
  localparam int unsigned CG_AW   = 6;
  localparam int unsigned CG_DEPTH = 1 << CG_AW;
  localparam logic [7:0]  BLANK   = 8'h20;
  localparam logic [6:0]  L2_BASE = 7'h40;
endpackage

// File: rtl/cdc_decode.sv
module cdc_decode
  import cdc_pkg::*;
(
  input  logic [7:0] code_i,
  output op_e        op_o
);
  // ascending scan: the highest set bit wins
  always_comb begin
    op_o = OP_NOP;
    for (int b = 0; b < 8; b++) begin
      if (code_i[b]) op_o = op_e'(4'(b + 1));
    end
  end
endmodule

// File: rtl/cdc_addr_step.sv
module cdc_addr_step
  import cdc_pkg::*;
#(
  parameter int unsigned LINE_CHARS = 40
) (
  input  logic [AC_W-1:0] ac_i,
  input  logic            up_i,
  input  logic            two_line_i,
  input  logic            cg_i,
  output logic [AC_W-1:0] ac_o
);
  localparam logic [AC_W-1:0] L1_END  = AC_W'(LINE_CHARS - 1);
  localparam logic [AC_W-1:0] L2_END  = AC_W'(32'h40 + LINE_CHARS - 1);
  localparam logic [AC_W-1:0] ONE_END = AC_W'(2 * LINE_CHARS - 1);

  always_comb begin
    if (cg_i) begin
      ac_o = {1'b0, up_i ? ac_i[CG_AW-1:0] + 1'b1 : ac_i[CG_AW-1:0] - 1'b1};
    end else if (two_line_i) begin
      if (up_i)
        ac_o = (ac_i == L1_END) ? L2_BASE : (ac_i == L2_END) ? '0 : ac_i + 1'b1;
      else
        ac_o = (ac_i == '0) ? L2_END : (ac_i == L2_BASE) ? L1_END : ac_i - 1'b1;
    end else begin
      if (up_i) ac_o = (ac_i == ONE_END) ? '0 : ac_i + 1'b1;
      else      ac_o = (ac_i == '0) ? ONE_END : ac_i - 1'b1;
    end
  end
endmodule

// File: rtl/cdc_busy_timer.sv
module cdc_busy_timer #(
  parameter int unsigned SHORT_CYC = 5000,
  parameter int unsigned LONG_CYC  = 205000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(LONG_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= long_i ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/char_disp_ctrl.sv
module char_disp_ctrl
  import cdc_pkg::*;
#(
  parameter int unsigned LINE_CHARS = 40,
  parameter int unsigned SHORT_CYC  = 5000,
  parameter int unsigned LONG_CYC   = 205000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       rs_i,
  input  logic       rw_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       busy_o,
  output logic       disp_on_o,
  output logic       cursor_on_o,
  output logic       blink_on_o,
  output logic       two_line_o,
  output logic       tall_font_o,
  output logic       wide_bus_o,
  output logic       entry_inc_o,
  output logic       entry_shift_o,
  output logic [6:0] shift_ofs_o
);
  localparam int unsigned DD_DEPTH = 2 * LINE_CHARS;
  localparam logic [6:0]  DD_NONE  = 7'(DD_DEPTH);
  localparam cfg_t        CFG_RST  = '{disp_on: 1'b0, cursor_on: 1'b0, blink_on: 1'b0,
                                       two_line: 1'b0, tall_font: 1'b0, wide_bus: 1'b1,
                                       inc: 1'b1, eshift: 1'b0};

  logic [7:0]      dd_mem [DD_DEPTH];
  logic [7:0]      cg_mem [CG_DEPTH];
  logic [AC_W-1:0] ac_q, ac_d, ac_step;
  logic            cg_sel_q, cg_sel_d;
  cfg_t            cfg_q, cfg_d;
  logic [6:0]      ofs_q, ofs_d, ofs_l, ofs_r, line_len;
  logic [7:0]      buf_q, pf_data;
  logic [6:0]      wr_idx, pf_idx;
  logic            load_buf, clear_mem, dd_we, cg_we, step_up, start, start_long;
  logic            accept, stat_rd, data_rd;
  op_e             op;

  function automatic logic [6:0] dd_index(input logic [6:0] a, input logic two);
    if (two) begin
      if (32'(a[5:0]) >= LINE_CHARS) return DD_NONE;
      return a[6] ? 7'(LINE_CHARS) + {1'b0, a[5:0]} : {1'b0, a[5:0]};
    end
    return (32'(a) < DD_DEPTH) ? a : DD_NONE;
  endfunction

  cdc_decode u_dec (.code_i(wdata_i), .op_o(op));

  cdc_addr_step #(.LINE_CHARS(LINE_CHARS)) u_step (
    .ac_i(ac_q), .up_i(step_up), .two_line_i(cfg_q.two_line),
    .cg_i(cg_sel_q), .ac_o(ac_step)
  );

  cdc_busy_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_busy (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .long_i(start_long), .busy_o(busy_o)
  );

  assign stat_rd  = req_i && !rs_i && rw_i;
  assign accept   = req_i && !busy_o && !stat_rd;
  assign data_rd  = accept && rs_i && rw_i;
  assign line_len = cfg_q.two_line ? 7'(LINE_CHARS) : 7'(DD_DEPTH);
  assign ofs_l    = (ofs_q == line_len - 1'b1) ? '0 : ofs_q + 1'b1;
  assign ofs_r    = (ofs_q == '0) ? line_len - 1'b1 : ofs_q - 1'b1;

  always_comb begin
    ac_d = ac_q; cg_sel_d = cg_sel_q; cfg_d = cfg_q; ofs_d = ofs_q;
    load_buf = 1'b0; clear_mem = 1'b0; dd_we = 1'b0; cg_we = 1'b0;
    start = 1'b0; start_long = 1'b0; step_up = cfg_q.inc;
    if (accept) begin
      if (rs_i) begin
        start = 1'b1;
        ac_d  = ac_step;
        if (rw_i) load_buf = 1'b1;
        else if (cg_sel_q) cg_we = 1'b1;
        else begin
          dd_we = 1'b1;
          if (cfg_q.eshift) ofs_d = cfg_q.inc ? ofs_l : ofs_r;
        end
      end else begin
        start = (op != OP_NOP);
        unique case (op)
          OP_CLEAR: begin
            clear_mem = 1'b1; start_long = 1'b1;
            ac_d = '0; cg_sel_d = 1'b0; ofs_d = '0; cfg_d.inc = 1'b1;
          end
          OP_HOME: begin
            start_long = 1'b1; ac_d = '0; cg_sel_d = 1'b0; ofs_d = '0;
          end
          OP_ENTRY: {cfg_d.inc, cfg_d.eshift} = wdata_i[1:0];
          OP_CTRL:  {cfg_d.disp_on, cfg_d.cursor_on, cfg_d.blink_on} = wdata_i[2:0];
          OP_FUNC:  {cfg_d.wide_bus, cfg_d.two_line, cfg_d.tall_font} = wdata_i[4:2];
          OP_SHIFT: begin
            if (wdata_i[3]) ofs_d = wdata_i[2] ? ofs_r : ofs_l;
            else begin
              step_up = wdata_i[2]; ac_d = ac_step; load_buf = 1'b1;
            end
          end
          OP_CG_ADDR: begin ac_d = {1'b0, wdata_i[5:0]}; cg_sel_d = 1'b1; load_buf = 1'b1; end
          OP_DD_ADDR: begin ac_d = wdata_i[6:0];         cg_sel_d = 1'b0; load_buf = 1'b1; end
          default: ;
        endcase
      end
    end
  end

  assign wr_idx  = dd_index(ac_q, cfg_q.two_line);
  assign pf_idx  = dd_index(ac_d, cfg_q.two_line);
  assign pf_data = cg_sel_d ? cg_mem[ac_d[CG_AW-1:0]]
                 : (pf_idx != DD_NONE) ? dd_mem[pf_idx] : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= BLANK;
      for (int i = 0; i < CG_DEPTH; i++) cg_mem[i] <= '0;
    end else if (clear_mem) begin
      for (int i = 0; i < DD_DEPTH; i++) dd_mem[i] <= BLANK;
    end else begin
      if (dd_we && wr_idx != DD_NONE) dd_mem[wr_idx] <= wdata_i;
      if (cg_we) cg_mem[ac_q[CG_AW-1:0]] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q <= '0; cg_sel_q <= 1'b0; cfg_q <= CFG_RST; ofs_q <= '0;
      buf_q <= '0; rdata_o <= '0;
    end else begin
      ac_q <= ac_d; cg_sel_q <= cg_sel_d; cfg_q <= cfg_d; ofs_q <= ofs_d;
      if (load_buf) buf_q <= pf_data;
      if (stat_rd)      rdata_o <= {busy_o, ac_q};
      else if (data_rd) rdata_o <= buf_q;
    end
  end

  assign disp_on_o     = cfg_q.disp_on;
  assign cursor_on_o   = cfg_q.cursor_on;
  assign blink_on_o    = cfg_q.blink_on;
  assign two_line_o    = cfg_q.two_line;
  assign tall_font_o   = cfg_q.tall_font;
  assign wide_bus_o    = cfg_q.wide_bus;
  assign entry_inc_o   = cfg_q.inc;
  assign entry_shift_o = cfg_q.eshift;
  assign shift_ofs_o   = ofs_q;
endmodule

// File: rtl/char_disp_ctrl_chk.sv
module char_disp_ctrl_chk #(
  parameter int unsigned LINE_CHARS = 40
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       rs_i,
  input logic       rw_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       busy_o,
  input logic [6:0] ac_q,
  input logic       cg_sel_q,
  input logic       two_line_o,
  input logic       entry_inc_o,
  input logic [6:0] shift_ofs_o
);
  localparam logic [6:0] L1_END = 7'(LINE_CHARS - 1);

  a_r11_busy_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && rs_i) |=> busy_o);

  a_r9_status_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !rs_i && rw_i) |=> (rdata_o == {$past(busy_o), $past(ac_q)}));

  a_r12_ignored_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o && !(!rs_i && rw_i)) |=> ($stable(ac_q) && $stable(shift_ofs_o)));

  a_r3_clear_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !rs_i && !rw_i && wdata_i == 8'h01)
      |=> (ac_q == 7'h00 && shift_ofs_o == 7'h00 && entry_inc_o));

  a_r6_line_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && rs_i && !rw_i && two_line_o && entry_inc_o && !cg_sel_q && ac_q == L1_END)
      |=> (ac_q == 7'h40));

  a_r7_read_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && rs_i && rw_i) |=> $stable(shift_ofs_o));
endmodule

bind char_disp_ctrl char_disp_ctrl_chk #(.LINE_CHARS(LINE_CHARS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rs_i(rs_i), .rw_i(rw_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o), .ac_q(ac_q),
  .cg_sel_q(cg_sel_q), .two_line_o(two_line_o), .entry_inc_o(entry_inc_o),
  .shift_ofs_o(shift_ofs_o)
);

// File: tb/char_disp_ctrl_tb.sv
module char_disp_ctrl_tb;
  localparam int SHORT = 3;
  localparam int LONG  = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] wd = '0, rdata;
  logic busy, d_on, c_on, b_on, two, tall, wide, inc, esh;
  logic [6:0] ofs;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  char_disp_ctrl #(.LINE_CHARS(40), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rs_i(rs), .rw_i(rw), .wdata_i(wd),
    .rdata_o(rdata), .busy_o(busy), .disp_on_o(d_on), .cursor_on_o(c_on),
    .blink_on_o(b_on), .two_line_o(two), .tall_font_o(tall), .wide_bus_o(wide),
    .entry_inc_o(inc), .entry_shift_o(esh), .shift_ofs_o(ofs)
  );

  // reference model
  logic [7:0] m_dd [80];
  logic [7:0] m_cg [64];
  logic [6:0] m_ac;
  logic       m_cgs, m_inc, m_esh, m_two, m_don, m_con, m_bon, m_tall, m_wide;
  int         m_ofs;
  logic [7:0] m_buf, m_rexp;

  function automatic logic [6:0] m_step(logic [6:0] a, logic up, logic tw, logic cg);
    if (cg) return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
    if (tw) begin
      if (up) return a == 7'h27 ? 7'h40 : a == 7'h67 ? 7'h00 : a + 7'd1;
      return a == 7'h00 ? 7'h67 : a == 7'h40 ? 7'h27 : a - 7'd1;
    end
    if (up) return a == 7'h4F ? 7'h00 : a + 7'd1;
    return a == 7'h00 ? 7'h4F : a - 7'd1;
  endfunction

  function automatic int m_idx(logic [6:0] a, logic tw);
    if (tw) return (a[5:0] < 40) ? (a[6] ? 40 + int'(a[5:0]) : int'(a[5:0])) : 80;
    return (a < 80) ? int'(a) : 80;
  endfunction

  function automatic logic [7:0] m_rd(logic [6:0] a, logic cg);
    int i;
    if (cg) return m_cg[a[5:0]];
    i = m_idx(a, m_two);
    return (i < 80) ? m_dd[i] : 8'h00;
  endfunction

  function automatic int m_len();
    return m_two ? 40 : 80;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
    for (int i = 0; i < 64; i++) m_cg[i] = 8'h00;
    m_ac = 0; m_cgs = 0; m_inc = 1; m_esh = 0; m_two = 0; m_don = 0; m_con = 0;
    m_bon = 0; m_tall = 0; m_wide = 1; m_ofs = 0; m_buf = 0; m_rexp = 0;
  endtask

  // returns expected busy length
  task automatic m_apply(input logic r_s, input logic r_w, input logic [7:0] d, output int bl);
    int i;
    bl = 0;
    if (!r_s && r_w) return;
    if (r_s) begin
      bl = SHORT;
      if (r_w) begin
        m_rexp = m_buf; m_ac = m_step(m_ac, m_inc, m_two, m_cgs); m_buf = m_rd(m_ac, m_cgs);
      end else begin
        if (m_cgs) m_cg[m_ac[5:0]] = d;
        else begin
          i = m_idx(m_ac, m_two);
          if (i < 80) m_dd[i] = d;
          if (m_esh) m_ofs = m_inc ? (m_ofs + 1) % m_len() : (m_ofs + m_len() - 1) % m_len();
        end
        m_ac = m_step(m_ac, m_inc, m_two, m_cgs);
      end
      return;
    end
    if (d == 8'h00) return;
    bl = (d[7:2] == 0) ? LONG : SHORT;
    if (d[7]) begin m_ac = d[6:0]; m_cgs = 0; m_buf = m_rd(m_ac, 0); end
    else if (d[6]) begin m_ac = {1'b0, d[5:0]}; m_cgs = 1; m_buf = m_rd(m_ac, 1); end
    else if (d[5]) {m_wide, m_two, m_tall} = d[4:2];
    else if (d[4]) begin
      if (d[3]) m_ofs = d[2] ? (m_ofs + m_len() - 1) % m_len() : (m_ofs + 1) % m_len();
      else begin m_ac = m_step(m_ac, d[2], m_two, m_cgs); m_buf = m_rd(m_ac, m_cgs); end
    end
    else if (d[3]) {m_don, m_con, m_bon} = d[2:0];
    else if (d[2]) {m_inc, m_esh} = d[1:0];
    else if (d[1]) begin m_ac = 0; m_cgs = 0; m_ofs = 0; end
    else begin
      for (int k = 0; k < 80; k++) m_dd[k] = 8'h20;
      m_ac = 0; m_cgs = 0; m_ofs = 0; m_inc = 1;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic r_s, input logic r_w, input logic [7:0] d);
    @(negedge clk); req = 1'b1; rs = r_s; rw = r_w; wd = d;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic do_op(input logic r_s, input logic r_w, input logic [7:0] d, input string tag);
    int bl, n;
    xfer(r_s, r_w, d);
    m_apply(r_s, r_w, d, bl);
    if (r_s && r_w) chk({tag, " read data"}, rdata, m_rexp);
    if (!r_s && r_w) chk({tag, " R9 status"}, rdata, {1'b0, m_ac});
    wait_idle(n);
    chk({tag, " R11 busy length"}, n, bl);
  endtask

  task automatic stat_chk(input logic [6:0] exp, input string tag);
    xfer(1'b0, 1'b1, 8'h00);
    chk({tag, " R9 counter"}, rdata, {1'b0, exp});
  endtask

  task automatic cfg_chk(input string tag);
    chk({tag, " offset"}, ofs, m_ofs);
    chk({tag, " flags"}, {d_on, c_on, b_on, two, tall, wide, inc, esh},
        {m_don, m_con, m_bon, m_two, m_tall, m_wide, m_inc, m_esh});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R11 busy never cleared actual=hung expected=done");
      summary();
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20417));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 idle", busy, 1'b0);
    chk("R1 flags", {d_on, c_on, b_on, two, tall, wide, inc, esh, ofs}, {8'b00000110, 7'd0});
    stat_chk(7'h00, "R1");
    do_op(0, 0, 8'h80, "R1 addr");
    do_op(1, 1, 8'h00, "R1");
    chk("R1 blank fill", rdata, 8'h20);

    // R11 busy lengths
    do_op(0, 0, 8'h06, "R11 entry");
    do_op(0, 0, 8'h01, "R11 clear");
    do_op(0, 0, 8'h03, "R11 home");
    do_op(1, 0, 8'h31, "R11 write");

    // R12 ignored while busy
    xfer(0, 0, 8'h01); m_apply(0, 0, 8'h01, n);
    xfer(0, 1, 8'h00);
    chk("R12 R9 status while busy", rdata, 8'h80);
    xfer(0, 0, 8'h85);
    xfer(1, 0, 8'h99);
    xfer(0, 0, 8'h18);
    wait_idle(n);
    stat_chk(7'h00, "R12");
    chk("R12 offset untouched", ofs, 7'd0);
    do_op(0, 0, 8'h80, "R12");
    do_op(1, 1, 8'h00, "R12");
    chk("R12 memory untouched", rdata, 8'h20);

    // R6 one-line wrap
    do_op(0, 0, 8'hCF, "R6"); do_op(1, 0, 8'h41, "R6");
    stat_chk(7'h00, "R6 one-line up");
    do_op(0, 0, 8'h04, "R6"); do_op(0, 0, 8'h80, "R6"); do_op(1, 0, 8'h42, "R6");
    stat_chk(7'h4F, "R6 one-line down");
    do_op(0, 0, 8'h06, "R6");

    // R2 function set, control and nop
    do_op(0, 0, 8'h3F, "R2 func");
    chk("R2 func flags", {wide, two, tall}, 3'b111);
    do_op(0, 0, 8'h38, "R2 func");
    chk("R2 func flags", {wide, two, tall}, 3'b110);
    do_op(0, 0, 8'h0F, "R2 ctrl");
    chk("R2 ctrl flags", {d_on, c_on, b_on}, 3'b111);
    do_op(0, 0, 8'h0A, "R2 ctrl");
    chk("R2 ctrl flags", {d_on, c_on, b_on}, 3'b010);
    do_op(0, 0, 8'h00, "R2 nop");
    cfg_chk("R2 nop");

    // R6 two-line wrap
    do_op(0, 0, 8'hA7, "R6"); do_op(1, 0, 8'h43, "R6");
    stat_chk(7'h40, "R6 line1 end");
    do_op(0, 0, 8'hE7, "R6"); do_op(1, 0, 8'h44, "R6");
    stat_chk(7'h00, "R6 line2 end");
    do_op(0, 0, 8'h04, "R6"); do_op(0, 0, 8'hC0, "R6"); do_op(1, 0, 8'h45, "R6");
    stat_chk(7'h27, "R6 line2 start down");
    do_op(0, 0, 8'h80, "R6"); do_op(1, 0, 8'h46, "R6");
    stat_chk(7'h67, "R6 zero down");
    do_op(0, 0, 8'h06, "R6");

    // R8 shift command
    do_op(0, 0, 8'h80, "R8");
    do_op(0, 0, 8'h18, "R8"); chk("R8 display left", ofs, 7'd1); stat_chk(7'h00, "R8 ac kept");
    do_op(0, 0, 8'h1C, "R8"); chk("R8 display right", ofs, 7'd0);
    do_op(0, 0, 8'h1F, "R8"); chk("R8 right wrap", ofs, 7'd39);
    do_op(0, 0, 8'h18, "R8"); chk("R8 left wrap", ofs, 7'd0);
    do_op(0, 0, 8'h10, "R8"); stat_chk(7'h67, "R8 cursor left");
    do_op(0, 0, 8'h17, "R8"); stat_chk(7'h00, "R8 cursor right");

    // R7 entry shift
    do_op(0, 0, 8'h07, "R7"); do_op(1, 0, 8'h50, "R7"); chk("R7 write left", ofs, 7'd1);
    do_op(1, 1, 8'h00, "R7"); chk("R7 read no shift", ofs, 7'd1);
    do_op(0, 0, 8'h05, "R7"); do_op(1, 0, 8'h51, "R7"); chk("R7 write right", ofs, 7'd0);
    do_op(1, 0, 8'h52, "R7"); chk("R7 right wrap", ofs, 7'd39);
    do_op(0, 0, 8'h06, "R7");

    // R10 stale first read
    do_op(0, 0, 8'h85, "R10"); do_op(1, 0, 8'h55, "R10");
    do_op(1, 1, 8'h00, "R10"); chk("R10 stale read", rdata, 8'h20);
    do_op(0, 0, 8'h85, "R10"); do_op(1, 1, 8'h00, "R10"); chk("R10 fresh read", rdata, 8'h55);

    // R5 glyph memory wrap
    do_op(0, 0, 8'h7F, "R5"); stat_chk(7'h3F, "R5 cg addr");
    do_op(1, 0, 8'hAA, "R5"); stat_chk(7'h00, "R5 cg wrap");
    do_op(0, 0, 8'h7F, "R5"); do_op(1, 1, 8'h00, "R5"); chk("R5 cg readback", rdata, 8'hAA);
    stat_chk(7'h00, "R5 read step");

    // R4 home keeps memory
    do_op(0, 0, 8'h83, "R4"); do_op(1, 0, 8'h41, "R4"); do_op(0, 0, 8'h18, "R4");
    do_op(0, 0, 8'h02, "R4"); chk("R4 offset", ofs, 7'd0); stat_chk(7'h00, "R4 home");
    do_op(0, 0, 8'h83, "R4"); do_op(1, 1, 8'h00, "R4"); chk("R4 kept", rdata, 8'h41);

    // R3 clear
    do_op(0, 0, 8'h05, "R3"); do_op(0, 0, 8'h01, "R3");
    chk("R3 entry", {inc, esh}, 2'b11); chk("R3 offset", ofs, 7'd0); stat_chk(7'h00, "R3");
    do_op(0, 0, 8'h83, "R3"); do_op(1, 1, 8'h00, "R3"); chk("R3 blanked", rdata, 8'h20);
    do_op(0, 0, 8'h06, "R3");

    // random mix against the model (R5 R6 R7 R8 R10)
    for (int it = 0; it < 600; it++) begin
      int k;
      logic [7:0] a;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: do_op(1, 0, 8'($urandom), "rnd R5 write");
        3, 4:    do_op(1, 1, 8'h00, "rnd R10 read");
        5: begin
          if (m_two) a = {1'b1, $urandom_range(0, 1) ? 1'b1 : 1'b0, 6'($urandom_range(0, 39))};
          else       a = {1'b1, 7'($urandom_range(0, 79))};
          do_op(0, 0, a, "rnd R2 dd addr");
        end
        6: do_op(0, 0, {2'b01, 6'($urandom)}, "rnd R2 cg addr");
        7: do_op(0, 0, {6'b000001, 2'($urandom)}, "rnd R7 entry");
        8: do_op(0, 0, {4'b0001, 4'($urandom)}, "rnd R8 shift");
        default: do_op(0, 1, 8'h00, "rnd");
      endcase
      if (it == 300) do_op(0, 0, 8'h30, "rnd R6 one-line");
      cfg_chk("rnd R7");
    end

    done = 1;
    summary();
  end
endmodule